// File: doc/BRIEF.md
# Programmable Down-Counting Interrupt Timer

The block is a single down-counter that software sets up through a small synchronous register port. Each register is selected by a word offset. The counter moves only on prescaled cycles of a tick-enable input. It can count as a 16-bit or a 32-bit counter. Three counting behaviours are available: free-running wrap from full scale, periodic reload from a stored limit, and one-shot stop at zero. Each time the count expires, a raw interrupt flag is set. Software clears that flag by writing to a clear location. The interrupt pin shows the flag gated by an interrupt-enable bit.

Two ways of changing the limit are offered. A direct load replaces the running count at once. A deferred load only changes the value used at the next periodic reload. The prescaler divides tick-enable pulses by 1, 16 or 256, and it starts again from zero whenever the control register is written.

Top module: `cdt_timer`

## Requirements
- R1: After reset, control reads 0x20 (timer disabled, interrupt enable set, free-running, 16-bit, divide by 1). The count, the stored limit and the raw flag read 0, and `irq` is low.
- R2: Word offsets are 0 direct load, 1 current count, 2 control, 3 interrupt clear, 4 raw status (bit 0), 5 masked status (bit 0), 6 deferred load. Offsets 3 and 7 read as zero. Control bits are: 0 one-shot, 1 wide (1 = 32-bit, 0 = 16-bit), 3:2 prescale, 5 interrupt enable, 6 periodic, 7 run.
- R3: A write to offset 0 stores the limit and sets the count to it in the next cycle. In 16-bit mode only the low 16 bits are used for the count. Offsets 0 and 6 both read back the full stored limit.
- R4: A write to offset 6 stores the limit and leaves the running count unchanged.
- R5: Writes to offset 1 have no effect on the count.
- R6: In periodic mode, a prescaled tick that finds the count at zero expires and reloads the limit. A limit of N therefore gives an expiry every N+1 prescaled ticks.
- R7: With periodic off and one-shot off, an expiry at zero wraps the count to 0xFFFF (16-bit) or 0xFFFFFFFF (32-bit).
- R8: In one-shot mode, after an expiry the count stays at zero and no further expiry occurs. This lasts until offset 0 is written or the run bit goes from 0 to 1.
- R9: Prescale code 00 steps the count on every tick, 01 on every 16th tick and 10 on every 256th tick. Any control write restarts the prescaler. While the run bit is 0 the count holds.
- R10: An expiry sets the raw flag. A write to offset 3 clears it. If both happen in the same cycle, the flag stays set.
- R11: Masked status and `irq` equal the raw flag ANDed with the interrupt-enable bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count tick qualifier, one pulse per cycle high |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register word offset |
| wdata | input | DATA_W | Register write data |
| rdata | output | DATA_W | Register read data for `addr`, combinational |
| irq | output | 1 | Masked interrupt |

## Verification
The counter is driven in turn through periodic reload, 16-bit and 32-bit free-running wrap, and one-shot runs. Each run is sampled just before and just after zero, which separates the reload source from the wrap value and from the one-shot hold. Tick bursts of 15 and 1, and of 255 and 1, after a control write show the exact division point and the prescaler restart. Paired writes to the direct load, the deferred load and the read-only count distinguish an immediate count change from a limit-only change and from no change. A clear that lands on the cycle of an expiry checks the priority between setting and clearing the flag.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

    // Register word offsets
    typedef enum logic [2:0] {
        OFS_LOAD   = 3'd0,
        OFS_VALUE  = 3'd1,
        OFS_CTRL   = 3'd2,
        OFS_ICLR   = 3'd3,
        OFS_RAW    = 3'd4,
        OFS_MASKED = 3'd5,
        OFS_BGLOAD = 3'd6
    } ofs_e;

    // Prescale codes
    typedef enum logic [1:0] {
        DIV_1   = 2'b00,
        DIV_16  = 2'b01,
        DIV_256 = 2'b10
    } div_e;

    // Control register, bit 7 down to bit 0
    typedef struct packed {
        logic       run;
        logic       periodic;
        logic       int_en;
        logic       spare;
        logic [1:0] div;
        logic       wide;
        logic       oneshot;
    } ctrl_t;

    localparam int    CTRL_W     = $bits(ctrl_t);
    localparam ctrl_t CTRL_RESET = '{run: 1'b0, periodic: 1'b0, int_en: 1'b1,
                                     spare: 1'b0, div: DIV_1, wide: 1'b0,
                                     oneshot: 1'b0};

    // Terminal prescaler count for a prescale code
    function automatic logic [7:0] div_last(input logic [1:0] code);
        case (code)
            DIV_16:  return 8'd15;
            DIV_256: return 8'd255;
            default: return 8'd0;
        endcase
    endfunction

endpackage

// File: rtl/cdt_prescaler.sv
module cdt_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       restart,
    input  logic       run,
    input  logic [1:0] sel,
    output logic       strobe
);
    import cdt_pkg::*;

    logic [PRE_W-1:0] pcnt_q;
    logic [PRE_W-1:0] last;

    assign last   = PRE_W'(div_last(sel));
    assign strobe = run && !restart && (pcnt_q == last);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pcnt_q <= '0;
        end else if (run) begin
            pcnt_q <= (pcnt_q == last) ? '0 : pcnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_wr,
    input  logic [DATA_W-1:0] load_val,
    input  logic [DATA_W-1:0] limit,
    input  logic              strobe,
    input  logic              wide,
    input  logic              periodic,
    input  logic              oneshot,
    input  logic              rearm,
    output logic [DATA_W-1:0] cnt_view,
    output logic [DATA_W-1:0] cnt_raw,
    output logic              expire
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] cnt_q;
    logic              done_q;
    logic [DATA_W-1:0] lim_view;
    logic [DATA_W-1:0] full;
    logic [DATA_W-1:0] load_view;

    function automatic logic [DATA_W-1:0] fit(input logic [DATA_W-1:0] x,
                                              input logic w);
        return w ? x : {{(DATA_W-HALF_W){1'b0}}, x[HALF_W-1:0]};
    endfunction

    assign cnt_view  = fit(cnt_q, wide);
    assign lim_view  = fit(limit, wide);
    assign load_view = fit(load_val, wide);
    assign full      = fit('1, wide);
    assign cnt_raw   = cnt_q;
    assign expire    = strobe && !load_wr && (cnt_view == '0) && !(oneshot && done_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (load_wr) begin
            cnt_q  <= load_view;
            done_q <= 1'b0;
        end else begin
            if (rearm) begin
                done_q <= 1'b0;
            end
            if (expire) begin
                done_q <= oneshot;
                if (oneshot)       cnt_q <= '0;
                else if (periodic) cnt_q <= lim_view;
                else               cnt_q <= full;
            end else if (strobe && cnt_view != '0) begin
                cnt_q <= cnt_view - 1'b1;
            end
        end
    end

endmodule

// File: rtl/cdt_timer.sv
module cdt_timer #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3,
    parameter int PRE_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    import cdt_pkg::*;

    ctrl_t             ctrl_q;
    ctrl_t             ctrl_new;
    logic [DATA_W-1:0] limit_q;
    logic              raw_q;
    logic              wr_load, wr_ctrl, wr_clr, wr_bg;
    logic              rearm;
    logic              pre_strobe;
    logic              cnt_expire;
    logic [DATA_W-1:0] cnt_view;
    logic [DATA_W-1:0] cnt_raw;

    assign wr_load  = wr_en && (addr == ADDR_W'(OFS_LOAD));
    assign wr_ctrl  = wr_en && (addr == ADDR_W'(OFS_CTRL));
    assign wr_clr   = wr_en && (addr == ADDR_W'(OFS_ICLR));
    assign wr_bg    = wr_en && (addr == ADDR_W'(OFS_BGLOAD));
    assign ctrl_new = ctrl_t'(wdata[CTRL_W-1:0]);
    assign rearm    = wr_ctrl && ctrl_new.run && !ctrl_q.run;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= CTRL_RESET;
            limit_q <= '0;
            raw_q   <= 1'b0;
        end else begin
            if (wr_ctrl)          ctrl_q  <= ctrl_new;
            if (wr_load || wr_bg) limit_q <= wdata;
            if (cnt_expire)       raw_q   <= 1'b1;
            else if (wr_clr)      raw_q   <= 1'b0;
        end
    end

    cdt_prescaler #(.PRE_W(PRE_W)) i_pre (
        .clk     (clk),
        .rst     (rst),
        .restart (wr_ctrl),
        .run     (ctrl_q.run && tick_en),
        .sel     (ctrl_q.div),
        .strobe  (pre_strobe)
    );

    cdt_counter #(.DATA_W(DATA_W)) i_cnt (
        .clk      (clk),
        .rst      (rst),
        .load_wr  (wr_load),
        .load_val (wdata),
        .limit    (limit_q),
        .strobe   (pre_strobe),
        .wide     (ctrl_q.wide),
        .periodic (ctrl_q.periodic),
        .oneshot  (ctrl_q.oneshot),
        .rearm    (rearm),
        .cnt_view (cnt_view),
        .cnt_raw  (cnt_raw),
        .expire   (cnt_expire)
    );

    assign irq = raw_q && ctrl_q.int_en;

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(OFS_LOAD),
            ADDR_W'(OFS_BGLOAD): rdata = limit_q;
            ADDR_W'(OFS_VALUE):  rdata = cnt_view;
            ADDR_W'(OFS_CTRL):   rdata = DATA_W'(ctrl_q);
            ADDR_W'(OFS_RAW):    rdata = DATA_W'(raw_q);
            ADDR_W'(OFS_MASKED): rdata = DATA_W'(irq);
            default:             rdata = '0;
        endcase
    end

endmodule

// File: rtl/cdt_checker.sv
module cdt_checker #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              irq,
    input logic              ctrl_run,
    input logic              ctrl_ie,
    input logic              raw,
    input logic              expire,
    input logic              strobe,
    input logic [DATA_W-1:0] cnt
);
    // R11
    irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl_ie |-> !irq);

    // R10
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        expire |=> raw);

    // R10
    flag_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_W'(3) && !expire) |=> !raw);

    // R5
    value_ro_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_W'(1) && !strobe) |=> $stable(cnt));

    // R4
    bgload_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_W'(6) && !strobe) |=> $stable(cnt));

    // R3
    load_take_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_W'(0)) |=> (cnt[DATA_W/2-1:0] == $past(wdata[DATA_W/2-1:0])));

    // R9
    stopped_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_run && !(wr_en && addr == ADDR_W'(0))) |=> $stable(cnt));

endmodule

bind cdt_timer cdt_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .irq      (irq),
    .ctrl_run (ctrl_q.run),
    .ctrl_ie  (ctrl_q.int_en),
    .raw      (raw_q),
    .expire   (cnt_expire),
    .strobe   (pre_strobe),
    .cnt      (cnt_raw)
);

// File: tb/test_cdt_timer.sv
module test_cdt_timer;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int AW = 3;

    typedef enum logic [1:0] { OP_WR = 2'd0, OP_RD = 2'd1, OP_TK = 2'd2 } op_e;

    typedef struct packed {
        logic [1:0]    op;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        logic [DW-1:0] e;
        logic [3:0]    req;
    } vec_t;

    localparam int NV = 63;
    localparam vec_t TBL [NV] = '{
        '{OP_WR, 3'd0, 32'd5,        32'd0,        4'd3},  // R3 direct load
        '{OP_RD, 3'd1, 32'd0,        32'd5,        4'd3},
        '{OP_WR, 3'd2, 32'hE2,       32'd0,        4'd6},  // run, periodic, ie, wide, /1
        '{OP_TK, 3'd0, 32'd3,        32'd0,        4'd9},
        '{OP_RD, 3'd1, 32'd0,        32'd2,        4'd9},  // R9 div by 1
        '{OP_TK, 3'd0, 32'd2,        32'd0,        4'd6},
        '{OP_RD, 3'd4, 32'd0,        32'd0,        4'd6},  // R6 no expiry yet at zero
        '{OP_TK, 3'd0, 32'd1,        32'd0,        4'd6},
        '{OP_RD, 3'd4, 32'd0,        32'd1,        4'd10}, // R10 set
        '{OP_RD, 3'd5, 32'd0,        32'd1,        4'd11}, // R11
        '{OP_RD, 3'd1, 32'd0,        32'd5,        4'd6},  // R6 reload
        '{OP_WR, 3'd3, 32'd0,        32'd0,        4'd10},
        '{OP_RD, 3'd4, 32'd0,        32'd0,        4'd10}, // R10 clear
        '{OP_WR, 3'd6, 32'd9,        32'd0,        4'd4},
        '{OP_RD, 3'd1, 32'd0,        32'd5,        4'd4},  // R4 count kept
        '{OP_RD, 3'd0, 32'd0,        32'd9,        4'd3},  // R3 readback
        '{OP_RD, 3'd6, 32'd0,        32'd9,        4'd4},
        '{OP_TK, 3'd0, 32'd6,        32'd0,        4'd6},
        '{OP_RD, 3'd1, 32'd0,        32'd9,        4'd6},  // R6 reload from deferred
        '{OP_RD, 3'd4, 32'd0,        32'd1,        4'd6},
        '{OP_WR, 3'd3, 32'd0,        32'd0,        4'd10},
        '{OP_WR, 3'd1, 32'h1234,     32'd0,        4'd5},
        '{OP_RD, 3'd1, 32'd0,        32'd9,        4'd5},  // R5 ignored
        '{OP_WR, 3'd2, 32'hA0,       32'd0,        4'd7},  // free 16-bit
        '{OP_TK, 3'd0, 32'd10,       32'd0,        4'd7},
        '{OP_RD, 3'd1, 32'd0,        32'h0000FFFF, 4'd7},  // R7 16-bit wrap
        '{OP_RD, 3'd4, 32'd0,        32'd1,        4'd7},
        '{OP_WR, 3'd3, 32'd0,        32'd0,        4'd10},
        '{OP_WR, 3'd0, 32'd1,        32'd0,        4'd3},
        '{OP_WR, 3'd2, 32'hA2,       32'd0,        4'd7},  // free 32-bit
        '{OP_TK, 3'd0, 32'd2,        32'd0,        4'd7},
        '{OP_RD, 3'd1, 32'd0,        32'hFFFFFFFF, 4'd7},  // R7 32-bit wrap
        '{OP_WR, 3'd2, 32'h82,       32'd0,        4'd11}, // ie off
        '{OP_RD, 3'd4, 32'd0,        32'd1,        4'd11},
        '{OP_RD, 3'd5, 32'd0,        32'd0,        4'd11}, // R11 masked off
        '{OP_WR, 3'd3, 32'd0,        32'd0,        4'd10},
        '{OP_WR, 3'd0, 32'd2,        32'd0,        4'd8},
        '{OP_WR, 3'd2, 32'hA1,       32'd0,        4'd8},  // one-shot
        '{OP_TK, 3'd0, 32'd3,        32'd0,        4'd8},
        '{OP_RD, 3'd1, 32'd0,        32'd0,        4'd8},  // R8 stopped
        '{OP_RD, 3'd4, 32'd0,        32'd1,        4'd8},
        '{OP_WR, 3'd3, 32'd0,        32'd0,        4'd10},
        '{OP_TK, 3'd0, 32'd5,        32'd0,        4'd8},
        '{OP_RD, 3'd1, 32'd0,        32'd0,        4'd8},
        '{OP_RD, 3'd4, 32'd0,        32'd0,        4'd8},  // R8 no re-expiry
        '{OP_WR, 3'd0, 32'd1,        32'd0,        4'd8},
        '{OP_TK, 3'd0, 32'd2,        32'd0,        4'd8},
        '{OP_RD, 3'd4, 32'd0,        32'd1,        4'd8},  // R8 rearmed by load
        '{OP_WR, 3'd3, 32'd0,        32'd0,        4'd10},
        '{OP_WR, 3'd0, 32'd3,        32'd0,        4'd9},
        '{OP_WR, 3'd2, 32'hC4,       32'd0,        4'd9},  // periodic, /16
        '{OP_TK, 3'd0, 32'd15,       32'd0,        4'd9},
        '{OP_RD, 3'd1, 32'd0,        32'd3,        4'd9},  // R9 not yet
        '{OP_TK, 3'd0, 32'd1,        32'd0,        4'd9},
        '{OP_RD, 3'd1, 32'd0,        32'd2,        4'd9},  // R9 16th tick
        '{OP_TK, 3'd0, 32'd32,       32'd0,        4'd9},
        '{OP_RD, 3'd1, 32'd0,        32'd0,        4'd9},
        '{OP_WR, 3'd2, 32'hC8,       32'd0,        4'd9},  // /256, prescaler restart
        '{OP_WR, 3'd0, 32'd4,        32'd0,        4'd9},
        '{OP_TK, 3'd0, 32'd255,      32'd0,        4'd9},
        '{OP_RD, 3'd1, 32'd0,        32'd4,        4'd9},
        '{OP_TK, 3'd0, 32'd1,        32'd0,        4'd9},
        '{OP_RD, 3'd1, 32'd0,        32'd3,        4'd9}   // R9 256th tick
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick_en = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          irq;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cdt_timer #(.DATA_W(DW), .ADDR_W(AW), .PRE_W(8)) i_cdt_timer (
        .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp, input int req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] exp, input int req);
        @(negedge clk);
        addr = a;
        #1 check(rdata, exp, req);
    endtask

    task automatic tk(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(posedge clk);
        #1 tick_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 state after reset
        rd(3'd2, 32'h20, 1);
        rd(3'd1, 32'd0, 1);
        check({31'd0, irq}, 32'd0, 1);

        for (int i = 0; i < NV; i++) begin
            case (TBL[i].op)
                OP_WR:   wr(TBL[i].a, TBL[i].d);
                OP_RD:   rd(TBL[i].a, TBL[i].e, int'(TBL[i].req));
                default: tk(int'(TBL[i].d));
            endcase
        end

        // R9 stopped timer holds
        wr(3'd2, 32'h48);
        tk(300);
        rd(3'd1, 32'd3, 9);
        // R2 unmapped and clear offsets read zero
        rd(3'd7, 32'd0, 2);
        rd(3'd3, 32'd0, 2);
        // R3 16-bit load keeps low half in count, full value in limit
        wr(3'd2, 32'h40);
        wr(3'd0, 32'h12345);
        rd(3'd1, 32'h2345, 3);
        rd(3'd0, 32'h12345, 3);
        // R11 irq pin follows enable
        wr(3'd0, 32'd0);
        wr(3'd2, 32'hE2);
        tk(1);
        @(negedge clk);
        check({31'd0, irq}, 32'd1, 11);
        wr(3'd2, 32'hC2);
        @(negedge clk);
        check({31'd0, irq}, 32'd0, 11);
        // R10 expiry and clear in the same cycle: flag stays set
        @(negedge clk);
        wr_en = 1'b1; addr = 3'd3; tick_en = 1'b1;
        @(posedge clk);
        #1 wr_en = 1'b0; tick_en = 1'b0;
        rd(3'd4, 32'd1, 10);
        wr(3'd3, 32'd0);
        rd(3'd4, 32'd0, 10);
        // R1 reset mid-run
        wr(3'd2, 32'hE2);
        tk(1);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        rd(3'd2, 32'h20, 1);
        rd(3'd0, 32'd0, 1);
        rd(3'd4, 32'd0, 1);
        check({31'd0, irq}, 32'd0, 1);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule